// File: doc/BRIEF.md
# Exception entry sequencer

This block carries out the entry into an exception handler after an interrupt or trap has been recognized. On a request it takes a copy of the incoming processor status word and the current program counter, module register and static base. It then builds the status word the handler will run with. Next it writes the saved state onto a downward-growing interrupt stack and reads a dispatch table. The memory traffic goes over a single 32-bit request/acknowledge port. When the sequence ends, the block presents the new program counter, status word, module register, static base and stack pointer, and pulses `done` for one cycle.

A configuration bit selects one of two entry styles. In the direct style the dispatch entry is itself the handler address, and only three memory references are made. In the descriptor style the entry is split into a new module number (low half) and an unsigned code offset (high half). The block then fetches that module's static base and program base from memory, and the handler address is the program base plus the offset. Interrupt vector acquisition, instruction decode, reset handling and exception return are done elsewhere.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are low and every `new_*` output is zero.
- R2: A request is taken only when `req_valid` is high while `busy` is low. A request raised while `busy` is high has no effect: the memory traffic and results of the running sequence are unchanged, and no second sequence starts after `done`.
- R3: The resulting status word equals the incoming one with bits 1 (trace), 8 (user mode) and 9 (user stack select) cleared. Bit 11 (maskable interrupt enable) is also cleared when `req_is_irq`=1, and is kept as it was when `req_is_irq`=0 (trap).
- R4: The first access writes address `cur_isp`-4 with data {incoming status word in bits 31:16, low half}. The low half is `cur_mod` in descriptor mode and 16'h0000 filler in direct mode. The second access writes `cur_pc` to `cur_isp`-8. Afterwards `new_isp` = `cur_isp`-8.
- R5: The third access reads the dispatch entry at `intbase` + `req_vector`×4.
- R6: With `cfg_direct`=1 exactly three accesses occur. `new_pc` equals the dispatch entry, while `new_mod` and `new_sb` equal `cur_mod` and `cur_sb`.
- R7: With `cfg_direct`=0, `new_mod` is entry bits 15:0. The fourth access reads the zero-extended new module number, and its data becomes `new_sb`.
- R8: With `cfg_direct`=0 the fifth and last access reads new module number + 8. `new_pc` is that data plus entry bits 31:16 zero-extended, modulo 2^32.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged. Each access advances only on its acknowledge.
- R10: `done` is high for exactly one cycle at the end of a sequence, `busy` falls right after it, and the `new_*` outputs then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request |
| req_is_irq | input | 1 | 1 = interrupt, 0 = trap |
| req_vector | input | 8 | Dispatch table index |
| cfg_direct | input | 1 | 1 = direct entry, 0 = descriptor entry |
| cur_pc | input | 32 | Program counter at entry |
| cur_psr | input | 16 | Status word at entry |
| cur_mod | input | 16 | Module register at entry |
| cur_sb | input | 32 | Static base at entry |
| cur_isp | input | 32 | Interrupt stack pointer at entry |
| intbase | input | 32 | Dispatch table base address |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Resulting program counter |
| new_psr | output | 16 | Resulting status word |
| new_mod | output | 16 | Resulting module register |
| new_sb | output | 32 | Resulting static base |
| new_isp | output | 32 | Resulting interrupt stack pointer |

## Verification
The assertions assume three things about the inputs. The memory side raises `mem_ack` only while `mem_req` is pending. `mem_rdata` is valid in the acknowledge cycle. The request inputs are meaningful only in the cycle a request is taken. The bench's responder acknowledges only an outstanding request, for one cycle, after a chosen wait of zero to two cycles, with read data computed from the address. It changes the request inputs only on falling edges. A dedicated case keeps `req_valid` high with a different vector throughout a sequence, to show the request is ignored.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PUSH_HI = 3'd1,
      ST_PUSH_PC = 3'd2,
      ST_RD_DISP = 3'd3,
      ST_RD_SB   = 3'd4,
      ST_RD_PB   = 3'd5,
      ST_DONE    = 3'd6
   } seq_state_t;

endpackage

// File: rtl/exc_psr_adjust.sv
module exc_psr_adjust #(
   parameter int HW      = 16,
   parameter int TRC_BIT = 1,
   parameter int USR_BIT = 8,
   parameter int STK_BIT = 9,
   parameter int IEN_BIT = 11
) (
   input  logic [HW-1:0] psr_in,
   input  logic          is_irq,
   output logic [HW-1:0] psr_out
);

   for (genvar i = 0; i < HW; i++) begin : g_bit
      if (i == TRC_BIT || i == USR_BIT || i == STK_BIT) begin : g_clr
         assign psr_out[i] = 1'b0;
      end else if (i == IEN_BIT) begin : g_ien
         assign psr_out[i] = psr_in[i] & ~is_irq;
      end else begin : g_keep
         assign psr_out[i] = psr_in[i];
      end
   end

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
   import exc_entry_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       direct,
   input  logic       step,
   output seq_state_t state
);

   seq_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:    if (start) nxt = ST_PUSH_HI;
         ST_PUSH_HI: if (step)  nxt = ST_PUSH_PC;
         ST_PUSH_PC: if (step)  nxt = ST_RD_DISP;
         ST_RD_DISP: if (step)  nxt = direct ? ST_DONE : ST_RD_SB;
         ST_RD_SB:   if (step)  nxt = ST_RD_PB;
         ST_RD_PB:   if (step)  nxt = ST_DONE;
         ST_DONE:               nxt = ST_IDLE;
         default:               nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen
   import exc_entry_pkg::*;
#(
   parameter int DW     = 32,
   parameter int VEC_W  = 8,
   parameter int PB_OFS = 8
) (
   input  seq_state_t      state,
   input  logic            direct,
   input  logic [DW-1:0]   isp,
   input  logic [DW-1:0]   tbl_base,
   input  logic [VEC_W-1:0] vector,
   input  logic [DW/2-1:0] saved_psr,
   input  logic [DW/2-1:0] mod,
   input  logic [DW-1:0]   pc,
   output logic            mem_req,
   output logic            mem_we,
   output logic [DW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata
);

   localparam int HW   = DW / 2;
   localparam int SLOT = DW / 8;

   logic [DW-1:0] push_addr, disp_addr, mod_addr;

   assign push_addr = isp - DW'(SLOT);
   assign disp_addr = tbl_base + {{(DW-VEC_W-2){1'b0}}, vector, 2'b00};
   assign mod_addr  = {{(DW-HW){1'b0}}, mod};

   always_comb begin
      mem_req   = 1'b1;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state)
         ST_PUSH_HI: begin
            mem_we    = 1'b1;
            mem_addr  = push_addr;
            mem_wdata = {saved_psr, direct ? {HW{1'b0}} : mod};
         end
         ST_PUSH_PC: begin
            mem_we    = 1'b1;
            mem_addr  = push_addr;
            mem_wdata = pc;
         end
         ST_RD_DISP: mem_addr = disp_addr;
         ST_RD_SB:   mem_addr = mod_addr;
         ST_RD_PB:   mem_addr = mod_addr + DW'(PB_OFS);
         default:    mem_req  = 1'b0;
      endcase
   end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int DW      = 32,
   parameter int VEC_W   = 8,
   parameter int PB_OFS  = 8,
   parameter int TRC_BIT = 1,
   parameter int USR_BIT = 8,
   parameter int STK_BIT = 9,
   parameter int IEN_BIT = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_is_irq,
   input  logic [VEC_W-1:0] req_vector,
   input  logic             cfg_direct,
   input  logic [DW-1:0]    cur_pc,
   input  logic [DW/2-1:0]  cur_psr,
   input  logic [DW/2-1:0]  cur_mod,
   input  logic [DW-1:0]    cur_sb,
   input  logic [DW-1:0]    cur_isp,
   input  logic [DW-1:0]    intbase,
   output logic             busy,
   output logic             mem_req,
   output logic             mem_we,
   output logic [DW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ack,
   input  logic [DW-1:0]    mem_rdata,
   output logic             done,
   output logic [DW-1:0]    new_pc,
   output logic [DW/2-1:0]  new_psr,
   output logic [DW/2-1:0]  new_mod,
   output logic [DW-1:0]    new_sb,
   output logic [DW-1:0]    new_isp
);

   localparam int HW   = DW / 2;
   localparam int SLOT = DW / 8;

   if (DW % 16 != 0 || DW < 32) begin : g_bad_dw
      $error("exc_entry_seq: DW must be a multiple of 16 and at least 32");
   end
   if (VEC_W + 2 > HW) begin : g_bad_vec
      $error("exc_entry_seq: VEC_W too wide for the dispatch index");
   end
   if (TRC_BIT >= HW || USR_BIT >= HW || STK_BIT >= HW || IEN_BIT >= HW) begin : g_bad_bit
      $error("exc_entry_seq: status bit position out of range");
   end

   seq_state_t      state;
   logic            start, step;
   logic            dir_q;
   logic [VEC_W-1:0] vec_q;
   logic [DW-1:0]   tbl_q;
   logic [HW-1:0]   spsr_q, ofs_q, psr_adj;

   assign busy  = (state != ST_IDLE);
   assign done  = (state == ST_DONE);
   assign start = req_valid && !busy;
   assign step  = mem_req && mem_ack;

   exc_psr_adjust #(
      .HW(HW), .TRC_BIT(TRC_BIT), .USR_BIT(USR_BIT),
      .STK_BIT(STK_BIT), .IEN_BIT(IEN_BIT)
   ) u_psr (
      .psr_in (cur_psr),
      .is_irq (req_is_irq),
      .psr_out(psr_adj)
   );

   exc_seq_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .direct(dir_q),
      .step  (step),
      .state (state)
   );

   exc_addr_gen #(.DW(DW), .VEC_W(VEC_W), .PB_OFS(PB_OFS)) u_addr (
      .state    (state),
      .direct   (dir_q),
      .isp      (new_isp),
      .tbl_base (tbl_q),
      .vector   (vec_q),
      .saved_psr(spsr_q),
      .mod      (new_mod),
      .pc       (new_pc),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= 1'b0;
         vec_q   <= '0;
         tbl_q   <= '0;
         spsr_q  <= '0;
         ofs_q   <= '0;
         new_pc  <= '0;
         new_psr <= '0;
         new_mod <= '0;
         new_sb  <= '0;
         new_isp <= '0;
      end else if (start) begin
         dir_q   <= cfg_direct;
         vec_q   <= req_vector;
         tbl_q   <= intbase;
         spsr_q  <= cur_psr;
         new_pc  <= cur_pc;
         new_psr <= psr_adj;
         new_mod <= cur_mod;
         new_sb  <= cur_sb;
         new_isp <= cur_isp;
      end else if (step) begin
         unique case (state)
            ST_PUSH_HI, ST_PUSH_PC: new_isp <= new_isp - DW'(SLOT);
            ST_RD_DISP: begin
               if (dir_q) begin
                  new_pc <= mem_rdata;
               end else begin
                  new_mod <= mem_rdata[HW-1:0];
                  ofs_q   <= mem_rdata[DW-1:HW];
               end
            end
            ST_RD_SB: new_sb <= mem_rdata;
            ST_RD_PB: new_pc <= mem_rdata + {{(DW-HW){1'b0}}, ofs_q};
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
   parameter int DW      = 32,
   parameter int TRC_BIT = 1,
   parameter int USR_BIT = 8,
   parameter int STK_BIT = 9,
   parameter int IEN_BIT = 11
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_is_irq,
   input logic [DW/2-1:0] cur_psr,
   input logic            busy,
   input logic            mem_req,
   input logic            mem_we,
   input logic [DW-1:0]   mem_addr,
   input logic [DW-1:0]   mem_wdata,
   input logic            mem_ack,
   input logic            done,
   input logic [DW/2-1:0] new_psr
);

   AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req); // R2

   AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy)); // R10

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R2

   AST_PSR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!new_psr[TRC_BIT] && !new_psr[USR_BIT] && !new_psr[STK_BIT])); // R3

   AST_IRQ_IEN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_is_irq) |=> !new_psr[IEN_BIT]); // R3

   AST_TRAP_IEN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && !req_is_irq) |=> (new_psr[IEN_BIT] == $past(cur_psr[IEN_BIT]))); // R3

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
   .DW(DW), .TRC_BIT(TRC_BIT), .USR_BIT(USR_BIT), .STK_BIT(STK_BIT), .IEN_BIT(IEN_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_is_irq(req_is_irq),
   .cur_psr   (cur_psr),
   .busy      (busy),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .done      (done),
   .new_psr   (new_psr)
);

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_is_irq = 1'b0, cfg_direct = 1'b0;
   logic [7:0]  req_vector = '0;
   logic [31:0] cur_pc = '0, cur_sb = '0, cur_isp = '0, intbase = '0;
   logic [15:0] cur_psr = '0, cur_mod = '0;
   logic        busy, mem_req, mem_we, done;
   logic [31:0] mem_addr, mem_wdata, new_pc, new_sb, new_isp;
   logic [15:0] new_psr, new_mod;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int n_chk = 0, n_err = 0, cycles = 0;
   int lat = 0, wcnt = 0, log_n = 0, stab_err = 0;
   logic        log_we[8];
   logic [31:0] log_addr[8], log_wdata[8];
   logic [31:0] snap_addr, snap_wdata;
   logic        snap_we;

   always #2.5 clk = ~clk;

   exc_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_irq(req_is_irq),
      .req_vector(req_vector), .cfg_direct(cfg_direct), .cur_pc(cur_pc),
      .cur_psr(cur_psr), .cur_mod(cur_mod), .cur_sb(cur_sb), .cur_isp(cur_isp),
      .intbase(intbase), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .done(done), .new_pc(new_pc), .new_psr(new_psr),
      .new_mod(new_mod), .new_sb(new_sb), .new_isp(new_isp)
   );

   function automatic logic [31:0] mfun(input logic [31:0] a);
      return (a * 32'h9E3779B1) ^ 32'hC3A50F17;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory responder: acknowledges a pending access after lat cycles, logs it
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
         end else if (mem_req) begin
            if (wcnt == 0) begin
               snap_addr = mem_addr; snap_we = mem_we; snap_wdata = mem_wdata;
            end else if (mem_addr !== snap_addr || mem_we !== snap_we || mem_wdata !== snap_wdata) begin
               stab_err++;
            end
            if (wcnt >= lat) begin
               mem_ack   = 1'b1;
               mem_rdata = mfun(mem_addr);
               if (log_n < 8) begin
                  log_we[log_n] = mem_we; log_addr[log_n] = mem_addr; log_wdata[log_n] = mem_wdata;
               end
               log_n++;
            end else begin
               wcnt++;
            end
         end
      end
   end

   task automatic run_exc(input bit irq, input logic [7:0] vec, input bit dir, input bit hold_other);
      logic [31:0] ent, exp_pc, exp_sb, sb_a, pb_a;
      logic [15:0] exp_psr, exp_mod;
      int exp_n, w;
      bit seen;
      @(negedge clk);
      cur_pc  = 32'h1000_0000 + 32'(vec) * 32'h111;
      cur_psr = 16'hFFFF ^ {vec, vec[3:0], 4'h0};
      cur_mod = 16'h0400 + 16'(vec);
      cur_sb  = 32'h5000_0000 | 32'(vec);
      cur_isp = 32'h0000_8000 + 32'(vec) * 16;
      intbase = 32'h0001_0000 + 32'(vec) * 256;
      req_is_irq = irq; req_vector = vec; cfg_direct = dir;
      req_valid = 1'b1; log_n = 0;
      @(negedge clk);
      if (hold_other) begin
         req_vector = vec ^ 8'h5A; req_is_irq = ~irq; cfg_direct = ~dir;
      end else begin
         req_valid = 1'b0;
      end
      seen = 0;
      for (int i = 0; i < 100 && !seen; i++) begin
         if (done) seen = 1; else @(negedge clk);
      end
      req_valid = 1'b0;
      chk(seen, "R10 done reached", 32'(seen), 32'd1);
      ent     = mfun(intbase + 32'(vec) * 4);
      exp_psr = cur_psr & ~16'h0302;
      if (irq) exp_psr = exp_psr & ~16'h0800;
      sb_a = {16'h0, ent[15:0]};
      pb_a = sb_a + 32'd8;
      if (dir) begin
         exp_n = 3; exp_pc = ent; exp_mod = cur_mod; exp_sb = cur_sb;
      end else begin
         exp_n = 5; exp_mod = ent[15:0]; exp_sb = mfun(sb_a);
         exp_pc = mfun(pb_a) + {16'h0, ent[31:16]};
      end
      chk(log_n == exp_n, dir ? "R6 access count" : "R8 access count", 32'(log_n), 32'(exp_n));
      if (log_n >= 3) begin
         chk(log_we[0] === 1'b1 && log_addr[0] === cur_isp - 4, "R4 push1 addr", log_addr[0], cur_isp - 4);
         chk(log_wdata[0] === {cur_psr, dir ? 16'h0 : cur_mod}, "R4 push1 data", log_wdata[0], {cur_psr, dir ? 16'h0 : cur_mod});
         chk(log_we[1] === 1'b1 && log_addr[1] === cur_isp - 8, "R4 push2 addr", log_addr[1], cur_isp - 8);
         chk(log_wdata[1] === cur_pc, "R4 push2 data", log_wdata[1], cur_pc);
         chk(log_we[2] === 1'b0 && log_addr[2] === intbase + 32'(vec) * 4, "R5 dispatch addr", log_addr[2], intbase + 32'(vec) * 4);
      end
      if (!dir && log_n >= 5) begin
         chk(log_we[3] === 1'b0 && log_addr[3] === sb_a, "R7 sb read addr", log_addr[3], sb_a);
         chk(log_we[4] === 1'b0 && log_addr[4] === pb_a, "R8 pb read addr", log_addr[4], pb_a);
      end
      chk(new_pc === exp_pc, dir ? "R6 new_pc" : "R8 new_pc", new_pc, exp_pc);
      chk(new_psr === exp_psr, "R3 new_psr", 32'(new_psr), 32'(exp_psr));
      chk(new_mod === exp_mod, dir ? "R6 new_mod" : "R7 new_mod", 32'(new_mod), 32'(exp_mod));
      chk(new_sb === exp_sb, dir ? "R6 new_sb" : "R7 new_sb", new_sb, exp_sb);
      chk(new_isp === cur_isp - 8, "R4 new_isp", new_isp, cur_isp - 8);
      @(negedge clk);
      chk(!done && !busy, "R10 done single pulse", {30'h0, done, busy}, 32'h0);
      w = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (busy || mem_req) w++;
      end
      chk(w == 0 && log_n == exp_n, hold_other ? "R2 busy request ignored" : "R10 stays idle", 32'(log_n), 32'(exp_n));
      chk(new_pc === exp_pc && new_isp === cur_isp - 8, "R10 outputs hold", new_pc, exp_pc);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(!busy && !done && !mem_req, "R1 reset controls", {29'h0, busy, done, mem_req}, 32'h0);
      chk(new_pc === 0 && new_sb === 0 && new_isp === 0 && new_psr === 0 && new_mod === 0,
          "R1 reset results", new_pc | new_sb | new_isp, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int m = 0; m < 4; m++) begin
         for (int v = 0; v < 256; v++) begin
            lat = (v + m) % 3;
            run_exc(m[0], 8'(v), m[1], 1'b0);
         end
      end
      lat = 2;
      run_exc(1'b1, 8'h3C, 1'b1, 1'b1);
      run_exc(1'b0, 8'hC3, 1'b0, 1'b1);
      chk(stab_err == 0, "R9 request stable while waiting", 32'(stab_err), 32'h0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_chk++; n_err++;
            $display("FAIL R10 watchdog expired actual=%0d expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
         end
      end
   end

endmodule